// File: doc/BRIEF.md
# Inter-Processor Mailbox Slot Bank

This block is a bank of mailbox slots that two processor cores share to hand each other fixed-length messages. Each slot holds one 32-bit mode word and a payload of eight 32-bit words. The bank is reached through a plain word-wide register read and write port. Slot `m` is mapped into a 64-byte window that starts at byte `0x40*m`. Inside that window the mode word sits at offset `0x0`, and payload word `k` sits at offset `0x4 + 4k`.

The mode word carries two fields. A one-hot state field in bits [7:4] takes the codes idle `0x1`, transmit `0x2`, receive `0x4` and acknowledge `0x8`. Bit 0 selects the acknowledge style: 1 is automatic and 0 is by interrupt. Software changes these fields with read-modify-write, so the bank keeps every mode bit exactly as it was last written.

The receiving core pulses a per-slot acknowledge input. That pulse moves the slot into the acknowledge state. From there the slot either drops back to idle on its own, or it holds in acknowledge and raises a one-cycle event toward the interrupt logic. A polling sender treats the slot as free once the state field reads idle.

Top module: `mbox_bank`

## Requirements
- R1: After reset, every slot's mode word reads `0x00000010` (state idle, bit 0 = 0), every payload word reads zero, and `ack_evt` is all zero.
- R2: Writing payload word `k` of slot `m` (byte address `0x40*m + 0x4 + 4k`, `k` in 0..7) stores the data. A read asserted in one cycle returns the stored word on `bus_rdata` from the next clock edge on.
- R3: A write to a slot's mode word (offset `0x0`) stores all 32 bits. The bank changes no bit of it except for the state-field updates of R6, R7 and R10.
- R4: Offsets `0x24` through `0x3C` of a slot window read as zero. Writes to those offsets change no mode or payload word.
- R5: A write to one slot leaves the mode and payload words of every other slot unchanged.
- R6: A clock edge that samples `rx_ack[m]` high sets slot `m`'s state field to `0x8`. A read issued in the following cycle returns that value.
- R7: While a slot's state field is `0x8` and bit 0 is 1, and neither a mode write nor an acknowledge hits that slot, the next edge sets the state field to `0x1` and keeps every other bit.
- R8: With bit 0 = 0, an acknowledge raises `ack_evt[m]` for exactly one cycle, the cycle after the sampling edge. The state field stays `0x8` until software writes it. No other slot's event bit rises. With bit 0 = 1, no event is raised.
- R9: Software writing state `0x1` into a slot that is in acknowledge returns it to idle. The read-back then shows `0x1` in bits [7:4].
- R10: When an acknowledge and a mode write to the same slot happen in the same cycle, the stored word takes the written data with bits [7:4] forced to `0x8`. The written bit 0 decides between R7 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe; data appears after the next edge |
| bus_addr | input | 11 | Byte address (slot in [10:6], word in [5:2]) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, held until the next read |
| rx_ack | input | 32 | Receiver acknowledge, one bit per slot |
| ack_evt | output | 32 | One-cycle acknowledge event per slot (interrupt mode) |

## Verification
A write strobed in one cycle is stored at the next edge. A read strobed in the following cycle captures it one edge later, so the bench drives every input on the falling edge and samples `bus_rdata` on the next falling edge. An acknowledge shows up on `ack_evt` and in the state field one edge after it is sampled. That is why the event bit is checked right after the acknowledge cycle, and why the read that sees state `0x8` in automatic mode is strobed immediately after it. A second read, one cycle later, must see idle. Random traffic never writes state `0x8` with bit 0 set, so the bench model never has to predict a self-timed return to idle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int WIN_BYTE_W = 6;   // 64-byte window per slot
    localparam int WIN_OFF_W  = 4;   // word offset inside a window
    localparam int STATE_LSB  = 4;
    localparam int STATE_W    = 4;
    localparam int AUTO_BIT   = 0;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 4'h1,
        ST_TX   = 4'h2,
        ST_RX   = 4'h4,
        ST_ACK  = 4'h8
    } slot_state_e;

    typedef struct packed {
        logic                 hit_mode;
        logic                 hit_pay;
        logic [WIN_OFF_W-1:0] pay_idx;
    } win_dec_t;

    function automatic win_dec_t decode_offset(logic [WIN_OFF_W-1:0] woff, int msg_words);
        win_dec_t d;
        d.hit_mode = (woff == '0);
        d.hit_pay  = (woff != '0) && (int'(woff) <= msg_words);
        d.pay_idx  = woff - 1'b1;
        return d;
    endfunction

    localparam logic [31:0] MODE_RESET = 32'h0000_0010;

endpackage

// File: rtl/mbox_addr_decode.sv
module mbox_addr_decode
    import mbox_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int MSG_WORDS = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int ADDR_W   = SLOT_W + WIN_BYTE_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SLOT_W-1:0] slot_sel,
    output logic              in_range,
    output win_dec_t          dec
);
    logic [1:0] unused_byte_lanes;

    assign unused_byte_lanes = addr[1:0];
    assign slot_sel = addr[ADDR_W-1:WIN_BYTE_W];
    assign in_range = (int'(slot_sel) < NUM_SLOTS);
    assign dec      = decode_offset(addr[WIN_BYTE_W-1:2], MSG_WORDS);
endmodule

// File: rtl/mbox_slot.sv
module mbox_slot
    import mbox_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MSG_WORDS = 8,
    localparam int IDX_W    = $clog2(MSG_WORDS)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_mode,
    input  logic                              wr_pay,
    input  logic [IDX_W-1:0]                  pay_idx,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic                              rx_ack,
    output logic [DATA_W-1:0]                 mode_q,
    output logic [MSG_WORDS-1:0][DATA_W-1:0]  pay_q,
    output logic                              ack_evt
);
    logic [DATA_W-1:0] mode_d;
    slot_state_e       cur_state;
    logic              auto_ack;

    assign cur_state = slot_state_e'(mode_q[STATE_LSB +: STATE_W]);
    assign auto_ack  = mode_q[AUTO_BIT];

    // Priority: receiver acknowledge > software write > automatic return.
    always_comb begin
        mode_d = mode_q;
        if (wr_mode) begin
            mode_d = wdata;
        end else if (cur_state == ST_ACK && auto_ack) begin
            mode_d[STATE_LSB +: STATE_W] = ST_IDLE;
        end
        if (rx_ack) begin
            mode_d[STATE_LSB +: STATE_W] = ST_ACK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= DATA_W'(MODE_RESET);
            ack_evt <= 1'b0;
        end else begin
            mode_q  <= mode_d;
            ack_evt <= rx_ack && !mode_d[AUTO_BIT];
        end
    end

    always_ff @(posedge clk) begin
        for (int w = 0; w < MSG_WORDS; w++) begin
            if (rst) begin
                pay_q[w] <= '0;
            end else if (wr_pay && int'(pay_idx) == w) begin
                pay_q[w] <= wdata;
            end
        end
    end
endmodule

// File: rtl/mbox_read_mux.sv
module mbox_read_mux
    import mbox_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int MSG_WORDS = 8,
    parameter int DATA_W    = 32,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int IDX_W    = $clog2(MSG_WORDS)
) (
    input  logic [NUM_SLOTS-1:0][DATA_W-1:0]                 mode_all,
    input  logic [NUM_SLOTS-1:0][MSG_WORDS-1:0][DATA_W-1:0]  pay_all,
    input  logic [SLOT_W-1:0]                                slot_sel,
    input  logic                                             in_range,
    input  win_dec_t                                         dec,
    output logic [DATA_W-1:0]                                rdata
);
    logic [IDX_W-1:0]           idx;
    logic [WIN_OFF_W-IDX_W-1:0] unused_idx_hi;

    assign idx           = dec.pay_idx[IDX_W-1:0];
    assign unused_idx_hi = dec.pay_idx[WIN_OFF_W-1:IDX_W];

    always_comb begin
        rdata = '0;
        if (in_range) begin
            if (dec.hit_mode) begin
                rdata = mode_all[slot_sel];
            end else if (dec.hit_pay) begin
                rdata = pay_all[slot_sel][idx];
            end
        end
    end
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
    import mbox_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int MSG_WORDS = 8,
    parameter int DATA_W    = 32,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int ADDR_W   = SLOT_W + WIN_BYTE_W,
    localparam int IDX_W    = $clog2(MSG_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_SLOTS-1:0] rx_ack,
    output logic [NUM_SLOTS-1:0] ack_evt
);
    logic [SLOT_W-1:0] slot_sel;
    logic              in_range;
    win_dec_t          dec;
    logic [DATA_W-1:0] rd_mux;

    logic [NUM_SLOTS-1:0][DATA_W-1:0]                mode_all;
    logic [NUM_SLOTS-1:0][MSG_WORDS-1:0][DATA_W-1:0] pay_all;

    mbox_addr_decode #(.NUM_SLOTS(NUM_SLOTS), .MSG_WORDS(MSG_WORDS)) u_dec (
        .addr     (bus_addr),
        .slot_sel (slot_sel),
        .in_range (in_range),
        .dec      (dec)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic hit;
        assign hit = bus_wr && in_range && (slot_sel == SLOT_W'(g));

        mbox_slot #(.DATA_W(DATA_W), .MSG_WORDS(MSG_WORDS)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .wr_mode (hit && dec.hit_mode),
            .wr_pay  (hit && dec.hit_pay),
            .pay_idx (dec.pay_idx[IDX_W-1:0]),
            .wdata   (bus_wdata),
            .rx_ack  (rx_ack[g]),
            .mode_q  (mode_all[g]),
            .pay_q   (pay_all[g]),
            .ack_evt (ack_evt[g])
        );
    end

    mbox_read_mux #(.NUM_SLOTS(NUM_SLOTS), .MSG_WORDS(MSG_WORDS), .DATA_W(DATA_W)) u_rmux (
        .mode_all (mode_all),
        .pay_all  (pay_all),
        .slot_sel (slot_sel),
        .in_range (in_range),
        .dec      (dec),
        .rdata    (rd_mux)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/mbox_bank_chk.sv
module mbox_bank_chk #(
    parameter int NUM_SLOTS = 32,
    parameter int MSG_WORDS = 8,
    parameter int DATA_W    = 32,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int ADDR_W   = SLOT_W + 6
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             bus_wr,
    input logic                             bus_rd,
    input logic [ADDR_W-1:0]                bus_addr,
    input logic [DATA_W-1:0]                bus_rdata,
    input logic [NUM_SLOTS-1:0]             rx_ack,
    input logic [NUM_SLOTS-1:0]             ack_evt,
    input logic [NUM_SLOTS-1:0][DATA_W-1:0] mode_all
);
    logic unmapped_rd;
    assign unmapped_rd = bus_rd && (int'(bus_addr[5:2]) > MSG_WORDS);

    // R4: unmapped offsets read as zero
    a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        unmapped_rd |=> bus_rdata == '0);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
        logic       mode_wr_hit;
        logic [3:0] st;
        assign mode_wr_hit = bus_wr && bus_addr[ADDR_W-1:6] == SLOT_W'(i) && bus_addr[5:2] == 4'd0;
        assign st = mode_all[i][7:4];

        a_r6_ack_enters: assert property (@(posedge clk) disable iff (rst)
            rx_ack[i] |=> st == 4'h8);

        a_r7_auto_idle: assert property (@(posedge clk) disable iff (rst)
            (st == 4'h8 && mode_all[i][0] && !rx_ack[i] && !mode_wr_hit)
            |=> (st == 4'h1 && mode_all[i][DATA_W-1:8] == $past(mode_all[i][DATA_W-1:8])
                 && mode_all[i][3:0] == $past(mode_all[i][3:0])));

        a_r8_evt_state: assert property (@(posedge clk) disable iff (rst)
            ack_evt[i] |-> (st == 4'h8 && !mode_all[i][0]));

        a_r8_evt_single: assert property (@(posedge clk) disable iff (rst)
            (ack_evt[i] && !rx_ack[i]) |=> !ack_evt[i]);

        a_r3_mode_hold: assert property (@(posedge clk) disable iff (rst)
            (!mode_wr_hit && !rx_ack[i] && !(st == 4'h8 && mode_all[i][0]))
            |=> $stable(mode_all[i]));
    end
endmodule

bind mbox_bank mbox_bank_chk #(
    .NUM_SLOTS(NUM_SLOTS), .MSG_WORDS(MSG_WORDS), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/sim_mbox_bank.sv
module sim_mbox_bank;
    localparam int NS = 32;
    localparam int MW = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_rd;
    logic [10:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [NS-1:0] rx_ack, ack_evt;

    int nchk = 0;
    int nfail = 0;

    logic [31:0] mode_m [NS];
    logic [31:0] pay_m  [NS][MW];

    always #10 clk = ~clk;   // 50 MHz

    mbox_bank u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_ack(rx_ack), .ack_evt(ack_evt)
    );

    function automatic logic [10:0] mk_addr(int slot, int woff);
        return {slot[4:0], woff[3:0], 2'b00};
    endfunction

    function automatic logic [31:0] expect_rd(int slot, int woff);
        if (woff == 0) return mode_m[slot];
        if (woff <= MW) return pay_m[slot][woff-1];
        return 32'h0;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(int slot, int woff, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = mk_addr(slot, woff); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (woff == 0) mode_m[slot] = d;
        else if (woff <= MW) pay_m[slot][woff-1] = d;
    endtask

    task automatic rd(int slot, int woff, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = mk_addr(slot, woff);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ack(int slot);
        rx_ack[slot] = 1'b1;
        @(negedge clk);
        rx_ack = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] r, d;
        void'($urandom(32'd20240611));
        rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0; rx_ack = '0;
        for (int s = 0; s < NS; s++) begin
            mode_m[s] = 32'h10;
            for (int w = 0; w < MW; w++) pay_m[s][w] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 ack_evt", ack_evt, '0);
        foreach (mode_m[s]) if (s % 7 == 0 || s == NS-1) begin
            rd(s, 0, r); chk("R1 mode", r, 32'h10);
            rd(s, 3, r); chk("R1 payload", r, 32'h0);
        end

        // R5 independence, directed
        wr(3, 1, 32'hDEAD_BEEF);
        rd(4, 1, r); chk("R5 neighbour payload", r, 32'h0);
        rd(3, 0, r); chk("R5 own mode", r, 32'h10);
        rd(3, 1, r); chk("R2 payload", r, 32'hDEAD_BEEF);

        // R4 directed: unmapped write then check whole window
        wr(31, 9, 32'hFFFF_FFFF);
        wr(31, 15, 32'hFFFF_FFFF);
        for (int w = 0; w < 16; w++) begin
            rd(31, w, r); chk("R4 window", r, expect_rd(31, w));
        end

        // random mix: R2, R3, R4, R5
        for (int n = 0; n < 400; n++) begin
            int s, w, op;
            s = $urandom_range(NS-1, 0);
            op = $urandom_range(3, 0);
            d = $urandom();
            case (op)
                0: begin w = $urandom_range(MW, 1); wr(s, w, d); end
                1: begin
                    if (d[7:4] == 4'h8) d[7:4] = 4'h2;
                    wr(s, 0, d);
                end
                2: begin w = $urandom_range(15, MW+1); wr(s, w, d); end
                default: ;
            endcase
            w = $urandom_range(15, 0);
            rd(s, w, r);
            if (w == 0) chk("R3 mode", r, expect_rd(s, w));
            else if (w <= MW) chk("R2 payload", r, expect_rd(s, w));
            else chk("R4 unmapped", r, 32'h0);
            s = $urandom_range(NS-1, 0);
            w = $urandom_range(MW, 0);
            rd(s, w, r); chk("R5 random slot", r, expect_rd(s, w));
        end

        // R6, R8: interrupt mode
        wr(7, 0, 32'hABCD_0020);
        ack(7);
        chk("R8 event raised", ack_evt, 32'h1 << 7);
        rd(7, 0, r); chk("R6 state ack", r, 32'hABCD_0080);
        chk("R8 event single", ack_evt, '0);
        rd(7, 0, r); chk("R8 holds ack", r, 32'hABCD_0080);
        // R9 software return to idle
        wr(7, 0, 32'hABCD_0010);
        rd(7, 0, r); chk("R9 idle", r, 32'hABCD_0010);
        chk("R9 no event", ack_evt, '0);

        // R7 automatic mode
        wr(12, 0, 32'h55AA_0021);
        ack(12);
        chk("R7 no event", ack_evt, '0);
        rd(12, 0, r); chk("R6 auto ack state", r, 32'h55AA_0081);
        rd(12, 0, r); chk("R7 auto idle", r, 32'h55AA_0011);
        mode_m[12] = 32'h55AA_0011;

        // R10 collision, automatic
        bus_wr = 1; bus_addr = mk_addr(20, 0); bus_wdata = 32'h1234_0041; rx_ack[20] = 1'b1;
        @(negedge clk);
        bus_wr = 0; rx_ack = '0;
        chk("R10 auto no event", ack_evt, '0);
        rd(20, 0, r); chk("R10 auto ack", r, 32'h1234_0081);
        rd(20, 0, r); chk("R10 auto idle", r, 32'h1234_0011);

        // R10 collision, interrupt
        bus_wr = 1; bus_addr = mk_addr(21, 0); bus_wdata = 32'h9876_0040; rx_ack[21] = 1'b1;
        @(negedge clk);
        bus_wr = 0; rx_ack = '0;
        chk("R10 irq event", ack_evt, 32'h1 << 21);
        rd(21, 0, r); chk("R10 irq ack", r, 32'h9876_0080);
        rd(21, 0, r); chk("R10 irq hold", r, 32'h9876_0080);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule